// File: doc/BRIEF.md
# Load/Store Effective-Address and MAR/MBR Sequencer

This block sits beside a simple processor's register file and walks one instruction through memory. When `start` arrives it fetches the instruction word from the program counter. The fetch address is held in the memory-address register (MAR) and the fetched word lands in the memory-buffer register (MBR), where both stay visible. If the instruction is a load or a store, the block then computes a data address and makes a second access, with MAR holding that address and MBR holding the data moved. Any other instruction finishes after the fetch.

Internally all addresses are byte addresses. The data address is the base register alone, the base plus a label, or the base plus a small positive offset. A run-time mode decides how register and label values are read. In word mode each unit is one 32-bit word, so they are scaled by four. In byte mode they are used as they are, and an address that is not word aligned is flagged and skipped. The immediate offset always counts words in both modes. Memory is synchronous: read data arrives one cycle after the address.

Top module: `ldst_mar_seq`

## Requirements
- R1: Reset clears MAR, MBR and `load_data` to zero and holds `mem_re`, `mem_we` and `done` low. Asserting reset during an operation abandons it.
- R2: A start accepted while idle drives `mem_re` with `mem_addr` equal to `pc` in the next cycle. Two cycles after acceptance, MBR holds the word read from that address.
- R3: With `addr_form` 2'b00 or 2'b11 (register indirect), the data byte address is `base_val` in byte mode and `base_val`×4 in word mode. `label_val` and `word_off` are ignored.
- R4: With `addr_form` 2'b01 (register plus label), the data byte address is `base_val + label_val` in byte mode and `(base_val + label_val)`×4 in word mode.
- R5: With `addr_form` 2'b10 (register plus offset), the data byte address is the scaled base plus `word_off`×4 in both modes.
- R6: Raising the base register by 1 in word mode, or by 4 in byte mode, selects the next 32-bit word.
- R7: For a load, MAR holds the data address once the fetch ends. When `done` pulses, MBR and `load_data` both hold the memory word at that address.
- R8: For a store, `mem_we` is high for exactly one cycle, with `mem_addr` set to the data address and `mem_wdata` set to the captured store data. MBR then holds that data.
- R9: When `is_ldst` is low, no data access is made, MAR keeps `pc`, and `done` pulses directly after the fetch.
- R10: In byte mode, a load or store whose data address has either of its two low bits set raises `misalign` together with `done`. No data access is made and MAR keeps `pc`. Word mode never flags.
- R11: `done` is a one-cycle pulse. It appears 2 cycles after acceptance for a fetch-only or misaligned instruction, and 4 cycles after acceptance for a load or store.
- R12: `start` is ignored while an operation is in progress. Operand inputs are captured at acceptance, so later changes do not affect the current operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one instruction when idle |
| pc | input | ADDR_W | Instruction fetch byte address |
| is_ldst | input | 1 | Instruction makes a data access |
| is_store | input | 1 | Data access is a write |
| byte_mode | input | 1 | 1: register/label are byte addresses; 0: word addresses |
| addr_form | input | 2 | 00/11 indirect, 01 plus label, 10 plus word offset |
| base_val | input | ADDR_W | Base register contents |
| label_val | input | ADDR_W | Label address |
| word_off | input | OFF_W | Positive offset in words |
| store_data | input | DATA_W | Data to write on a store |
| mem_rdata | input | DATA_W | Read data, valid one cycle after the address |
| mem_addr | output | ADDR_W | Memory byte address (follows MAR) |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| load_data | output | DATA_W | Last loaded data word |
| mar | output | ADDR_W | Memory-address register |
| mbr | output | DATA_W | Memory-buffer register |
| done | output | 1 | One-cycle completion pulse |
| misalign | output | 1 | Last load/store skipped for misalignment |

## Verification
The checker assumes that memory answers a read one cycle after `mem_re`, so MBR can be compared with the bus without a handshake. It also assumes that `rst_n` is driven low from time zero, so the reset-clearing property never sees undefined values. The bench meets both assumptions: its word array registers read data on every edge, and reset is driven low before the first edge. All inputs are changed only on falling edges. Every data address the bench uses falls inside the modelled array, so no access wraps past its end.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_FETCH = 2'd1,
      SQ_DATA  = 2'd2
   } seq_state_t;

   typedef enum logic [1:0] {
      AM_IND     = 2'b00,
      AM_LABEL   = 2'b01,
      AM_OFFSET  = 2'b10,
      AM_IND_ALT = 2'b11
   } addr_form_t;

endpackage

// File: rtl/ldst_ea_calc.sv
module ldst_ea_calc
   import ldst_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int OFF_W     = 8,
   parameter int LANE_BITS = 2
) (
   input  logic              byte_mode,
   input  logic [1:0]        form,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [ADDR_W-1:0] label_val,
   input  logic [OFF_W-1:0]  word_off,
   output logic [ADDR_W-1:0] ea,
   output logic              misalign
);

   logic [ADDR_W-1:0] base_b;
   logic [ADDR_W-1:0] label_b;
   logic [ADDR_W-1:0] off_b;
   logic [ADDR_W-1:0] addend;

   // register and label scale with the mode; the offset always counts words
   always_comb begin
      base_b  = byte_mode ? base_val  : (base_val  << LANE_BITS);
      label_b = byte_mode ? label_val : (label_val << LANE_BITS);
      off_b   = ADDR_W'(word_off) << LANE_BITS;
      unique case (addr_form_t'(form))
         AM_LABEL:  addend = label_b;
         AM_OFFSET: addend = off_b;
         default:   addend = '0;
      endcase
      ea = base_b + addend;
   end

   generate
      if (LANE_BITS > 0) begin : g_lane
         assign misalign = byte_mode && (|ea[LANE_BITS-1:0]);
      end else begin : g_nolane
         assign misalign = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/ldst_seq_ctrl.sv
module ldst_seq_ctrl
   import ldst_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic is_ldst,
   input  logic is_store,
   input  logic misalign_ea,
   output logic accept,
   output logic mem_re,
   output logic mem_we,
   output logic ld_mar_ea,
   output logic ld_mbr_rd,
   output logic ld_mbr_wd,
   output logic ld_load,
   output logic done,
   output logic misalign
);

   seq_state_t state_q, state_n;
   logic       ph_q, ph_n;
   logic       done_n;
   logic       chk_miss;

   always_comb begin
      state_n   = state_q;
      ph_n      = ph_q;
      accept    = 1'b0;
      mem_re    = 1'b0;
      mem_we    = 1'b0;
      ld_mar_ea = 1'b0;
      ld_mbr_rd = 1'b0;
      ld_mbr_wd = 1'b0;
      ld_load   = 1'b0;
      done_n    = 1'b0;
      chk_miss  = 1'b0;
      unique case (state_q)
         SQ_IDLE: begin
            if (start) begin
               accept  = 1'b1;
               state_n = SQ_FETCH;
               ph_n    = 1'b0;
            end
         end
         SQ_FETCH: begin
            if (!ph_q) begin
               mem_re = 1'b1;
               ph_n   = 1'b1;
            end else begin
               ld_mbr_rd = 1'b1;
               ph_n      = 1'b0;
               chk_miss  = 1'b1;
               if (is_ldst && !misalign_ea) begin
                  ld_mar_ea = 1'b1;
                  state_n   = SQ_DATA;
               end else begin
                  state_n = SQ_IDLE;
                  done_n  = 1'b1;
               end
            end
         end
         SQ_DATA: begin
            if (!ph_q) begin
               if (is_store) begin
                  mem_we    = 1'b1;
                  ld_mbr_wd = 1'b1;
               end else begin
                  mem_re = 1'b1;
               end
               ph_n = 1'b1;
            end else begin
               if (!is_store) begin
                  ld_mbr_rd = 1'b1;
                  ld_load   = 1'b1;
               end
               ph_n    = 1'b0;
               state_n = SQ_IDLE;
               done_n  = 1'b1;
            end
         end
         default: state_n = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         ph_q     <= 1'b0;
         done     <= 1'b0;
         misalign <= 1'b0;
      end else begin
         state_q <= state_n;
         ph_q    <= ph_n;
         done    <= done_n;
         if (accept)
            misalign <= 1'b0;
         else if (chk_miss)
            misalign <= is_ldst && misalign_ea;
      end
   end

endmodule

// File: rtl/ldst_mar_mbr.sv
module ldst_mar_mbr #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_pc,
   input  logic [ADDR_W-1:0] pc,
   input  logic              ld_ea,
   input  logic [ADDR_W-1:0] ea,
   input  logic              ld_rd,
   input  logic [DATA_W-1:0] rdata,
   input  logic              ld_wd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ld_load,
   output logic [ADDR_W-1:0] mar,
   output logic [DATA_W-1:0] mbr,
   output logic [DATA_W-1:0] load_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mar       <= '0;
         mbr       <= '0;
         load_data <= '0;
      end else begin
         if (ld_pc)
            mar <= pc;
         else if (ld_ea)
            mar <= ea;
         if (ld_rd)
            mbr <= rdata;
         else if (ld_wd)
            mbr <= wdata;
         if (ld_load)
            load_data <= rdata;
      end
   end

endmodule

// File: rtl/ldst_mar_seq.sv
module ldst_mar_seq
   import ldst_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int OFF_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] pc,
   input  logic              is_ldst,
   input  logic              is_store,
   input  logic              byte_mode,
   input  logic [1:0]        addr_form,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [ADDR_W-1:0] label_val,
   input  logic [OFF_W-1:0]  word_off,
   input  logic [DATA_W-1:0] store_data,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              mem_re,
   output logic [DATA_W-1:0] load_data,
   output logic [ADDR_W-1:0] mar,
   output logic [DATA_W-1:0] mbr,
   output logic              done,
   output logic              misalign
);

   localparam int LANES     = DATA_W / 8;
   localparam int LANE_BITS = (LANES > 1) ? $clog2(LANES) : 0;

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0 || (1 << LANE_BITS) != LANES) begin : g_bad_data_w
         $error("DATA_W must be a power-of-two number of bytes");
      end
      if (OFF_W + LANE_BITS > ADDR_W) begin : g_bad_off_w
         $error("scaled offset does not fit in ADDR_W");
      end
   endgenerate

   // operands captured when an instruction is accepted
   logic              bm_q, ldst_q, st_q;
   logic [1:0]        form_q;
   logic [ADDR_W-1:0] base_q, label_q;
   logic [OFF_W-1:0]  off_q;
   logic [DATA_W-1:0] wdata_q;

   logic              accept;
   logic              ld_mar_ea, ld_mbr_rd, ld_mbr_wd, ld_load;
   logic [ADDR_W-1:0] ea;
   logic              ea_miss;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bm_q    <= 1'b0;
         ldst_q  <= 1'b0;
         st_q    <= 1'b0;
         form_q  <= '0;
         base_q  <= '0;
         label_q <= '0;
         off_q   <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         bm_q    <= byte_mode;
         ldst_q  <= is_ldst;
         st_q    <= is_store;
         form_q  <= addr_form;
         base_q  <= base_val;
         label_q <= label_val;
         off_q   <= word_off;
         wdata_q <= store_data;
      end
   end

   ldst_ea_calc #(
      .ADDR_W    (ADDR_W),
      .OFF_W     (OFF_W),
      .LANE_BITS (LANE_BITS)
   ) u_ea (
      .byte_mode (bm_q),
      .form      (form_q),
      .base_val  (base_q),
      .label_val (label_q),
      .word_off  (off_q),
      .ea        (ea),
      .misalign  (ea_miss)
   );

   ldst_seq_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .is_ldst     (ldst_q),
      .is_store    (st_q),
      .misalign_ea (ea_miss),
      .accept      (accept),
      .mem_re      (mem_re),
      .mem_we      (mem_we),
      .ld_mar_ea   (ld_mar_ea),
      .ld_mbr_rd   (ld_mbr_rd),
      .ld_mbr_wd   (ld_mbr_wd),
      .ld_load     (ld_load),
      .done        (done),
      .misalign    (misalign)
   );

   ldst_mar_mbr #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_pc     (accept),
      .pc        (pc),
      .ld_ea     (ld_mar_ea),
      .ea        (ea),
      .ld_rd     (ld_mbr_rd),
      .rdata     (mem_rdata),
      .ld_wd     (ld_mbr_wd),
      .wdata     (wdata_q),
      .ld_load   (ld_load),
      .mar       (mar),
      .mbr       (mbr),
      .load_data (load_data)
   );

   assign mem_addr  = mar;
   assign mem_wdata = wdata_q;

endmodule

// File: rtl/ldst_seq_chk.sv
module ldst_seq_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_we,
   input logic              mem_re,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [ADDR_W-1:0] mar,
   input logic [DATA_W-1:0] mbr,
   input logic              done,
   input logic              misalign
);

   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (mar == '0 && mbr == '0));

   p_one_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   p_store_to_mbr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (mbr == $past(mem_wdata)));

   p_rd_wr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!mem_re && !mem_we));

   p_miss_keeps_mar_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && misalign) |-> $stable(mar));

   p_miss_no_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (!mem_we && !mem_re));

endmodule

bind ldst_mar_seq ldst_seq_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_we    (mem_we),
   .mem_re    (mem_re),
   .mem_wdata (mem_wdata),
   .mar       (mar),
   .mbr       (mbr),
   .done      (done),
   .misalign  (misalign)
);

// File: tb/tb_ldst_mar_seq.sv
module tb_ldst_mar_seq;

   localparam int AW = 16;
   localparam int DW = 32;
   localparam int OW = 8;

   typedef struct packed {
      logic          bm;
      logic [1:0]    form;
      logic          st;
      logic [AW-1:0] base;
      logic [AW-1:0] label;
      logic [OW-1:0] off;
      logic [DW-1:0] wdata;
      logic [AW-1:0] ea;
      logic [DW-1:0] exp;
      logic [3:0]    req;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 2'd0, 1'b0, 16'd5,     16'd7,    8'd9, 32'h0,        16'h0014, 32'hA500_0005, 4'd3}, // R3 word indirect, label ignored
      '{1'b1, 2'd0, 1'b0, 16'h0028,  16'h0,    8'd0, 32'h0,        16'h0028, 32'hA500_000A, 4'd3}, // R3 byte indirect
      '{1'b0, 2'd1, 1'b0, 16'd3,     16'd10,   8'd0, 32'h0,        16'h0034, 32'hA500_000D, 4'd4}, // R4 word plus label
      '{1'b1, 2'd1, 1'b0, 16'h0008,  16'h0040, 8'd0, 32'h0,        16'h0048, 32'hA500_0012, 4'd4}, // R4 byte plus label
      '{1'b0, 2'd2, 1'b0, 16'd2,     16'h55,   8'd3, 32'h0,        16'h0014, 32'hA500_0005, 4'd5}, // R5 word plus offset
      '{1'b1, 2'd2, 1'b0, 16'h0010,  16'h0,    8'd3, 32'h0,        16'h001C, 32'hA500_0007, 4'd5}, // R5 byte plus offset
      '{1'b0, 2'd0, 1'b0, 16'd6,     16'h0,    8'd0, 32'h0,        16'h0018, 32'hA500_0006, 4'd6}, // R6 word step by 1
      '{1'b1, 2'd0, 1'b0, 16'h002C,  16'h0,    8'd0, 32'h0,        16'h002C, 32'hA500_000B, 4'd6}, // R6 byte step by 4
      '{1'b0, 2'd2, 1'b1, 16'd40,    16'h0,    8'd2, 32'hDEADBEEF, 16'h00A8, 32'hDEADBEEF, 4'd8}, // R8 store
      '{1'b1, 2'd0, 1'b0, 16'h00A8,  16'h0,    8'd0, 32'h0,        16'h00A8, 32'hDEADBEEF, 4'd7}, // R7 load back
      '{1'b0, 2'd3, 1'b0, 16'd9,     16'd4,    8'd1, 32'h0,        16'h0024, 32'hA500_0009, 4'd3}, // R3 form 11
      '{1'b1, 2'd2, 1'b1, 16'h0100,  16'h0,    8'd1, 32'h12345678, 16'h0104, 32'h12345678, 4'd8}  // R8 byte-mode store
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] pc = '0;
   logic          is_ldst = 1'b0;
   logic          is_store = 1'b0;
   logic          byte_mode = 1'b0;
   logic [1:0]    addr_form = '0;
   logic [AW-1:0] base_val = '0;
   logic [AW-1:0] label_val = '0;
   logic [OW-1:0] word_off = '0;
   logic [DW-1:0] store_data = '0;
   logic [DW-1:0] mem_rdata;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_we, mem_re;
   logic [DW-1:0] load_data;
   logic [AW-1:0] mar;
   logic [DW-1:0] mbr;
   logic          done, misalign;

   always #2 clk = ~clk;

   ldst_mar_seq #(.ADDR_W(AW), .DATA_W(DW), .OFF_W(OW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .pc(pc),
      .is_ldst(is_ldst), .is_store(is_store), .byte_mode(byte_mode),
      .addr_form(addr_form), .base_val(base_val), .label_val(label_val),
      .word_off(word_off), .store_data(store_data), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_re(mem_re), .load_data(load_data), .mar(mar), .mbr(mbr),
      .done(done), .misalign(misalign)
   );

   // synchronous word memory, read data one cycle after the address
   logic [DW-1:0] mem [256];
   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 | 32'(i);
   end
   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[9:2]];
   end

   int errors = 0;
   int checks = 0;

   task automatic check(input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // drives operands on a falling edge; returns one falling edge after acceptance
   task automatic launch(input logic bm, input logic [1:0] fm, input logic ls,
                         input logic st, input logic [AW-1:0] b,
                         input logic [AW-1:0] l, input logic [OW-1:0] o,
                         input logic [DW-1:0] wd, input logic [AW-1:0] p);
      @(negedge clk);
      byte_mode = bm; addr_form = fm; is_ldst = ls; is_store = st;
      base_val = b; label_val = l; word_off = o; store_data = wd; pc = p;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_vec(input vec_t v, input int i);
      logic [AW-1:0] p;
      logic [DW-1:0] instr;
      string tag;
      p = 16'h0040 + 16'(i * 4);
      instr = 32'hA500_0000 | 32'(16 + i);
      tag = $sformatf("R%0d", v.req);
      launch(v.bm, v.form, 1'b1, v.st, v.base, v.label, v.off, v.wdata, p);
      check("R2", "fetch re", 32'(mem_re), 32'd1);
      check("R2", "fetch addr", 32'(mem_addr), 32'(p));
      @(negedge clk); @(negedge clk);
      check("R2", "mbr instr", mbr, instr);
      check(tag, "mar ea", 32'(mar), 32'(v.ea));
      check(tag, "mem_we", 32'(mem_we), 32'(v.st));
      @(negedge clk); @(negedge clk);
      check("R11", "done ldst", 32'(done), 32'd1);
      check(tag, "mbr data", mbr, v.exp);
      if (!v.st) check("R7", "load_data", load_data, v.exp);
      @(negedge clk);
      check("R11", "done low", 32'(done), 32'd0);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "mar", 32'(mar), 32'd0);
      check("R1", "mbr", mbr, 32'd0);
      check("R1", "load_data", load_data, 32'd0);
      check("R1", "strobes", {29'd0, mem_re, mem_we, done}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
      check("R8", "mem word 65", mem[65], 32'h12345678);

      // R9: no data access, done after fetch
      launch(1'b0, 2'd0, 1'b0, 1'b0, 16'd5, 16'd0, 8'd0, 32'h0, 16'h0080);
      @(negedge clk); @(negedge clk);
      check("R11", "done fetch-only", 32'(done), 32'd1);
      check("R9", "mbr instr", mbr, 32'hA500_0020);
      check("R9", "mar keeps pc", 32'(mar), 32'h0080);
      @(negedge clk);
      check("R9", "no access", {30'd0, mem_re, mem_we}, 32'd0);

      // R10: misaligned byte-mode load
      launch(1'b1, 2'd0, 1'b1, 1'b0, 16'h0029, 16'd0, 8'd0, 32'h0, 16'h0084);
      @(negedge clk); @(negedge clk);
      check("R10", "done+misalign", {30'd0, done, misalign}, 32'd3);
      check("R10", "mar keeps pc", 32'(mar), 32'h0084);
      @(negedge clk);
      check("R10", "no access", {30'd0, mem_re, mem_we}, 32'd0);

      // R10: misaligned byte-mode store leaves memory alone
      launch(1'b1, 2'd2, 1'b1, 1'b1, 16'h0102, 16'd0, 8'd1, 32'hCAFEF00D, 16'h0088);
      repeat (4) @(negedge clk);
      check("R10", "store misalign flag", 32'(misalign), 32'd1);
      check("R10", "word 65 intact", mem[65], 32'h12345678);
      check("R10", "word 64 intact", mem[64], 32'hA500_0040);

      // R10: the same base in word mode is aligned
      launch(1'b0, 2'd0, 1'b1, 1'b0, 16'h0029, 16'd0, 8'd0, 32'h0, 16'h008C);
      repeat (4) @(negedge clk);
      check("R10", "word mode no flag", {30'd0, done, misalign}, 32'd2);
      check("R10", "word mode data", mbr, 32'hA500_0029);

      // R12: start and operands changed while busy are ignored
      launch(1'b0, 2'd0, 1'b1, 1'b0, 16'd7, 16'd0, 8'd0, 32'h0, 16'h0090);
      start = 1'b1; pc = 16'h0200; base_val = 16'd1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check("R12", "ea from captured base", 32'(mar), 32'h001C);
      @(negedge clk); @(negedge clk);
      check("R12", "data", mbr, 32'hA500_0007);
      @(negedge clk);
      check("R12", "no second fetch", 32'(mem_re), 32'd0);
      check("R12", "mar held", 32'(mar), 32'h001C);

      // R1: reset in the middle of an operation
      launch(1'b0, 2'd0, 1'b1, 1'b0, 16'd3, 16'd0, 8'd0, 32'h0, 16'h0094);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", "mid-op mar", 32'(mar), 32'd0);
      check("R1", "mid-op mbr", mbr, 32'd0);
      check("R1", "mid-op strobes", {30'd0, mem_re, mem_we}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", "stays idle", {30'd0, mem_re, done}, 32'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule